// File: doc/BRIEF.md
# Dual-Address I2C Memory Slave

This block is an I2C target that runs on a fast system clock. It synchronizes SCL and SDA and looks for edges on the synchronized copies. It pulls SDA low through an open-drain output enable. It answers on two 7-bit bus addresses, and each address owns its own 256-byte storage bank. The auxiliary bank sits on a fixed address set by a parameter. The main bank takes its address from a configuration input. When both addresses are equal, the main bank wins.

A master writes to a bank in two steps. The byte after the address loads that bank's memory pointer, and every byte after that is stored at the pointer, which then steps forward. A read with no pointer byte first returns data from wherever that bank's pointer was left. A random read loads the pointer in a write, then issues a repeated start and reads. Storage lives outside the block. The block gives the banks one-cycle write and read strobes, and it expects read data on the cycle after the read strobe.

Top module: `dual_bank_i2c_slave`

## Requirements
- R1: A start is SDA falling while synchronized SCL is high, and a stop is SDA rising while SCL is high. A stop at any point releases SDA (`sda_oe` = 0), ends the transfer and raises no strobe for an unfinished byte.
- R2: The first byte after a start carries the 7-bit address in bits 7..1 and the direction in bit 0 (0 = master writes, 1 = master reads). If the address equals `AUX_ADDR` (default 7'h50, byte A0h) or `main_addr_i` (A2h byte, 7'h51, at the bench's default), the slave acknowledges by holding SDA low through the ninth clock.
- R3: When `main_addr_i` equals `AUX_ADDR`, a transfer to that address reaches the main bank (`wr_bank`/`rd_bank` = 1). Bank code 0 means auxiliary and bank code 1 means main.
- R4: On any other address the slave does not acknowledge. Until the next start it never drives SDA and raises no `wr_en` or `rd_en`.
- R5: In a write, the second byte loads the selected bank's pointer. Each later byte raises `wr_en` for one cycle with `wr_bank`, `wr_addr` (the pointer) and `wr_data`, and the slave acknowledges every byte. `wr_en` and `rd_en` are never high together.
- R6: Each bank's pointer steps by one after every data byte written or fetched for reading and wraps from FFh to 00h. Each bank keeps its own pointer across transfers.
- R7: Read data goes out most significant bit first. SDA changes only after SCL falls, never while SCL is high. Each byte is fetched with a single-cycle `rd_en` at the pointer and captured from `rd_data` one cycle later.
- R8: A master NACK after a read byte ends the transfer. SDA stays released, and no further `rd_en` follows until a new start.
- R9: A repeated start restarts address decoding, so a pointer write followed by a repeated-start read returns the data at the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| main_addr_i | input | 7 | Bus address of the main bank |
| wr_en | output | 1 | One-cycle write strobe |
| wr_bank | output | 1 | Bank for the write (0 auxiliary, 1 main) |
| wr_addr | output | AW | Byte address for the write |
| wr_data | output | 8 | Byte to write |
| rd_en | output | 1 | One-cycle read strobe |
| rd_bank | output | 1 | Bank for the read |
| rd_addr | output | AW | Byte address for the read |
| rd_data | input | 8 | Read byte, valid the cycle after `rd_en` |

## Verification
The bench writes across the FFh boundary of the main bank. A pointer that failed to wrap, or that was shared between the two banks, would show up as a wrong `wr_addr` or as wrong data in the later current-address read. A stop partway through a data byte must leave the loaded pointer unchanged and raise no write. A design that committed partial bytes, or stepped the pointer on a stop, would be caught by the read that follows. After the main address is set equal to the auxiliary one, the bench expects bank 1. A design with the priority backwards would write the auxiliary bank instead. During a transfer to a foreign address, any SDA drive or strobe fails the check. After the closing NACK of a read, an extra prefetch fails it too.

// File: rtl/dual_bank_i2c_slave.sv
module dual_bank_i2c_slave #(
  parameter logic [6:0] AUX_ADDR = 7'h50,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [6:0]    main_addr_i,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data
);
  localparam int NB = 2;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA, K_READ} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  st_t        st;
  kind_t      kind;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       bank, rd_pend;
  logic [AW-1:0] ptr [NB];

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire hit_main  = (sh[7:1] == main_addr_i);
  wire hit_aux   = (sh[7:1] == AUX_ADDR);
  wire is_idle   = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= K_ADDR;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      bank    <= 1'b0;
      rd_pend <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_bank <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_en   <= 1'b0;
      rd_bank <= 1'b0;
      rd_addr <= '0;
      for (int i = 0; i < NB; i++) ptr[i] <= '0;
    end else begin
      wr_en   <= 1'b0;
      rd_en   <= 1'b0;
      rd_pend <= rd_en;
      if (rd_pend) tx <= rd_data;
      if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (hit_main || hit_aux) begin
                    bank   <= hit_main;
                    sda_oe <= 1'b1;
                    st     <= S_ACK;
                    if (sh[0]) begin
                      kind          <= K_READ;
                      rd_en         <= 1'b1;
                      rd_bank       <= hit_main;
                      rd_addr       <= ptr[hit_main];
                      ptr[hit_main] <= ptr[hit_main] + 1'b1;
                    end else begin
                      kind <= K_PTR;
                    end
                  end else begin
                    st <= S_IDLE;
                  end
                end
                K_PTR: begin
                  ptr[bank] <= AW'(sh);
                  kind      <= K_DATA;
                  sda_oe    <= 1'b1;
                  st        <= S_ACK;
                end
                default: begin
                  wr_en     <= 1'b1;
                  wr_bank   <= bank;
                  wr_addr   <= ptr[bank];
                  wr_data   <= sh;
                  ptr[bank] <= ptr[bank] + 1'b1;
                  sda_oe    <= 1'b1;
                  st        <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_READ) begin
                st     <= S_TX;
                sda_oe <= ~tx[7];
              end else begin
                st     <= S_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[6:0], 1'b0};
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                st <= S_IDLE;
              end else begin
                rd_en     <= 1'b1;
                rd_bank   <= bank;
                rd_addr   <= ptr[bank];
                ptr[bank] <= ptr[bank] + 1'b1;
              end
            end else if (scl_fall) begin
              st     <= S_TX;
              cnt    <= '0;
              sda_oe <= ~tx[7];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_bank_i2c_slave_chk.sv
module dual_bank_i2c_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          wr_en,
  input logic          wr_bank,
  input logic [AW-1:0] wr_addr,
  input logic          rd_en,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          is_idle
);
  logic          seq_ok, last_bank;
  logic [AW-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_ok    <= 1'b0;
      last_bank <= 1'b0;
      last_addr <= '0;
    end else if (start_det || stop_det) begin
      seq_ok <= 1'b0;
    end else if (wr_en) begin
      seq_ok    <= 1'b1;
      last_bank <= wr_bank;
      last_addr <= wr_addr;
    end
  end

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && is_idle)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> (!sda_oe && !rd_en)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seq_ok && wr_bank == last_bank) |-> (wr_addr == AW'(last_addr + 1'b1))); // R6
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R7
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R7
endmodule

bind dual_bank_i2c_slave dual_bank_i2c_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_en(wr_en), .wr_bank(wr_bank),
  .wr_addr(wr_addr), .rd_en(rd_en), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .is_idle(is_idle)
);

// File: tb/dual_bank_i2c_slave_tb.sv
`timescale 1ns/1ps
module dual_bank_i2c_slave_tb;
  localparam int Q = 10;
  localparam logic [6:0] AUXA = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] main_cfg = 7'h51;
  logic sda_oe, wr_en, wr_bank, rd_en, rd_bank;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  dual_bank_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .main_addr_i(main_cfg), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  logic [7:0] mem [2][256];
  logic [7:0] exp_mem [2][256];
  logic [7:0] exp_ptr [2];
  logic [16:0] wq [$];
  int total = 0, fails = 0;
  bit ign = 0, nack_win = 0;
  int ign_bad = 0, nack_rd = 0;
  logic prev_oe = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 256; i++) begin
        mem[b][i]     = 8'(i) ^ (b == 1 ? 8'h5A : 8'hC3);
        exp_mem[b][i] = 8'(i) ^ (b == 1 ? 8'h5A : 8'hC3);
      end
    exp_ptr[0] = 8'h00;
    exp_ptr[1] = 8'h00;
  end

  always @(posedge clk) begin
    if (wr_en) mem[wr_bank][wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_bank][rd_addr];
  end

  // per-clock comparison against the reference model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (wr_en) begin
        if (wq.size() == 0) chk(1'b0, "R5", "unexpected write", {wr_bank, wr_addr, wr_data}, 0);
        else begin
          logic [16:0] e;
          e = wq.pop_front();
          chk({wr_bank, wr_addr, wr_data} == e, "R5", "write strobe", {wr_bank, wr_addr, wr_data}, e);
        end
      end
      if (sda_oe !== prev_oe)
        chk(scl_m == 1'b0, "R7", "SDA changed with SCL high", scl_m, 0);
      if (ign && (sda_oe || wr_en || rd_en)) ign_bad++;
      if (nack_win && rd_en) nack_rd++;
      prev_oe = sda_oe;
    end
  end

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic write_byte(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = (sda_line == 1'b0);
    qw(); scl_m = 1'b0; qw();
  endtask

  task automatic read_byte(input bit nack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
      d = {d[6:0], sda_line};
      qw(); scl_m = 1'b0; qw();
    end
    if (nack) nack_win = 1'b1;
    send_bit(nack);
  endtask

  function automatic int tgt(input logic [6:0] a);
    if (a == main_cfg) return 1;
    if (a == AUXA) return 0;
    return -1;
  endfunction

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] p, input int n,
                         input logic [7:0] d0, input string req);
    bit ack;
    int b;
    b = tgt(a);
    i2c_start();
    write_byte({a, 1'b0}, ack);
    chk(ack == 1'b1, "R2", "address ack on write", ack, 1);
    write_byte(p, ack);
    chk(ack == 1'b1, "R5", "pointer ack", ack, 1);
    exp_ptr[b] = p;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = d0 + 8'(i);
      wq.push_back({1'(b), exp_ptr[b], d});
      exp_mem[b][exp_ptr[b]] = d;
      exp_ptr[b] = exp_ptr[b] + 8'd1;
      write_byte(d, ack);
      chk(ack == 1'b1, req, "data ack", ack, 1);
    end
    i2c_stop();
  endtask

  task automatic rd_bytes(input int b, input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      read_byte(i == n - 1, d);
      chk(d == exp_mem[b][exp_ptr[b]], req, "read data", d, exp_mem[b][exp_ptr[b]]);
      exp_ptr[b] = exp_ptr[b] + 8'd1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    qw();
    chk(sda_oe == 0 && wr_en == 0 && rd_en == 0, "R1", "reset outputs", {sda_oe, wr_en, rd_en}, 0);

    // auxiliary write
    wr_xfer(AUXA, 8'h20, 3, 8'hA1, "R5");
    // main write across the wrap
    wr_xfer(7'h51, 8'hFE, 3, 8'h71, "R6");
    chk(wq.size() == 0, "R6", "writes consumed after wrap", wq.size(), 0);

    // random read of auxiliary with repeated start
    i2c_start();
    write_byte({AUXA, 1'b0}, ack);
    chk(ack, "R9", "address ack before repeated start", ack, 1);
    write_byte(8'h1F, ack);
    chk(ack, "R9", "pointer ack before repeated start", ack, 1);
    exp_ptr[0] = 8'h1F;
    i2c_start();
    write_byte({AUXA, 1'b1}, ack);
    chk(ack, "R9", "read address ack after repeated start", ack, 1);
    rd_bytes(0, 4, "R9");
    qw();
    chk(sda_oe == 0, "R8", "SDA released after NACK", sda_oe, 0);
    i2c_stop();
    nack_win = 1'b0;
    chk(nack_rd == 0, "R8", "no fetch after NACK", nack_rd, 0);

    // current-address read from main, pointer persisted after wrap
    i2c_start();
    write_byte({7'h51, 1'b1}, ack);
    chk(ack, "R2", "main read ack", ack, 1);
    rd_bytes(1, 2, "R6");
    i2c_stop();
    nack_win = 1'b0;

    // foreign address
    i2c_start();
    ign = 1'b1;
    write_byte({7'h33, 1'b0}, ack);
    chk(!ack, "R4", "no ack on foreign address", ack, 0);
    write_byte(8'h00, ack);
    write_byte(8'hFF, ack);
    ign = 1'b0;
    i2c_stop();
    chk(ign_bad == 0, "R4", "quiet while ignoring", ign_bad, 0);

    // stop in the middle of a data byte
    i2c_start();
    write_byte({AUXA, 1'b0}, ack);
    write_byte(8'h10, ack);
    chk(ack, "R1", "pointer ack before stop", ack, 1);
    exp_ptr[0] = 8'h10;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop();
    qw();
    chk(sda_oe == 0 && wq.size() == 0, "R1", "stop mid-byte releases", sda_oe, 0);
    i2c_start();
    write_byte({AUXA, 1'b1}, ack);
    rd_bytes(0, 1, "R1");
    i2c_stop();
    nack_win = 1'b0;

    // equal addresses: main wins
    main_cfg = AUXA;
    wr_xfer(AUXA, 8'h05, 2, 8'h3C, "R3");
    i2c_start();
    write_byte({AUXA, 1'b1}, ack);
    rd_bytes(1, 1, "R3");
    i2c_stop();
    nack_win = 1'b0;
    chk(mem[1][5] == 8'h3C && mem[0][5] == (8'h05 ^ 8'hC3), "R3", "main bank received write",
        mem[1][5], 8'h3C);
    chk(wq.size() == 0, "R5", "all writes seen", wq.size(), 0);

    qw();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule